// File: doc/BRIEF.md
# Windowed Signed Multiply-Accumulate

This block turns a continuous stream of signed sample/coefficient pairs into a series of short dot products. On every clock edge it multiplies the sample and coefficient presented at its inputs and adds the product to a running sum. At the end of each window it places the finished sum on its result output for capture by a downstream consumer or memory. At the same time it raises a one-cycle valid strobe and presents the index of that window as an address.

There is no gap between windows. On the edge that ends a window, the accumulator is loaded with the product arriving on that edge instead of being cleared. Every input pair therefore belongs to exactly one window, and a result appears every nine cycles for as long as the stream runs. Arithmetic is two's complement on eight bits and wraps with no saturation.

Top module: `win_mac`

## Requirements
- R1: An active-high reset, applied at any time and without waiting for a clock edge, drives the result, the valid strobe and the address to zero and restarts window counting.
- R2: Each product is the sample (5-bit two's complement, range -16..15) times the coefficient (3-bit two's complement, range -4..3), both sign-extended to 8 bits, taken modulo 256. For example, sample 5'b10000 with coefficient 3'b011 gives 8'd208 (-48).
- R3: Counting rising edges after reset release from 1, edge 8k+(k-1)... stated plainly: the first result covers the products of edges 1 to 8. Every later result covers nine consecutive products, starting with the product taken on the edge that ends the previous strobe cycle.
- R4: The valid strobe is high for exactly one cycle, following edges 8, 17, 26 and so on after reset release. It is low at all other times.
- R5: The result output changes only on the edge that raises the valid strobe, and it holds its value in all other cycles.
- R6: While the strobe is high, the address equals the number of results delivered before this one, modulo 256. The address increments on the edge that ends the strobe cycle and holds otherwise.
- R7: Consecutive strobes are exactly nine cycles apart and no input pair is skipped between windows.
- R8: Sums wrap modulo 256. For example, nine products of sample 5'b10000 times coefficient 3'b100 (+64 each) give 8'd64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| sample_i | input | SMP_W (5) | Signed sample, consumed on every edge |
| coef_i | input | COEF_W (3) | Signed coefficient, consumed on every edge |
| sum_o | output | ACC_W (8) | Most recent completed window sum |
| sum_valid_o | output | 1 | One-cycle strobe marking a new sum |
| sum_addr_o | output | ADDR_W (8) | Index of the window whose sum is shown |

## Verification
The assertions rely on the input stream never pausing: every edge consumes one pair, and the block has no enable. They also assume reset is the only event that realigns the window phase. The stimulus follows these assumptions by driving a fresh pair on every falling edge without gaps. The only break in the stream is one asynchronous reset applied in the middle of a window, after which the reference model restarts its own phase at zero. Operand values cover the full signed ranges, including the most negative sample and coefficient. They include windows that overflow eight bits, and the run is long enough to wrap the address.

// File: rtl/win_mac.sv
module win_mac #(
  parameter int SMP_W  = 5,
  parameter int COEF_W = 3,
  parameter int ACC_W  = 8,
  parameter int TERMS  = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [ACC_W-1:0]  sum_o,
  output logic              sum_valid_o,
  output logic [ADDR_W-1:0] sum_addr_o
);
  localparam int CNT_W = $clog2(TERMS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERMS - 1);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(TERMS - 2);

  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] smp_x, coef_x;
  logic [ACC_W-1:0] prod, acc_next;

  assign smp_x    = ACC_W'($signed(sample_i));
  assign coef_x   = ACC_W'($signed(coef_i));
  assign prod     = ACC_W'(smp_x * coef_x);
  assign acc_next = acc + prod;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt         <= '0;
      acc         <= '0;
      sum_o       <= '0;
      sum_valid_o <= 1'b0;
      sum_addr_o  <= '0;
    end else begin
      sum_valid_o <= (cnt == PRE);
      if (cnt == PRE) sum_o <= acc_next;
      if (cnt == LAST) begin
        cnt        <= '0;
        acc        <= prod;
        sum_addr_o <= sum_addr_o + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        acc <= acc_next;
      end
    end
  end

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    sum_valid_o |=> !sum_valid_o);
  assert_sum_held_R5: assert property (@(posedge clk) disable iff (rst)
    !sum_valid_o |=> (sum_valid_o || $stable(sum_o)));
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    sum_valid_o |=> sum_addr_o == $past(sum_addr_o) + 1'b1);
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !sum_valid_o |=> $stable(sum_addr_o));
endmodule

// File: tb/test_win_mac.sv
module test_win_mac;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [4:0] smp;
  logic [2:0] cof;
  wire  [7:0] sum;
  wire        vld;
  wire  [7:0] adr;

  win_mac i_win_mac (.clk(clk), .rst(rst), .sample_i(smp), .coef_i(cof),
                     .sum_o(sum), .sum_valid_o(vld), .sum_addr_o(adr));

  int checks = 0, fails = 0, idx = 0, prev_strobe = -1;
  logic [7:0] ws = 8'd0, last_sum = 8'd0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mul_ref(input logic [4:0] a, input logic [2:0] b);
    int ia, ib;
    ia = $signed(a);
    ib = $signed(b);
    return 8'(ia * ib);
  endfunction

  // each call: one pair consumed on one rising edge, outputs checked at the falling edge
  task automatic step(input logic [4:0] a, input logic [2:0] b);
    bit exp_v;
    smp = a; cof = b;
    @(posedge clk);
    @(negedge clk);
    if (idx % 9 == 8) ws = mul_ref(a, b);
    else ws = ws + mul_ref(a, b);
    exp_v = (idx % 9 == 7);
    chk(vld == exp_v, "R4", vld, exp_v);
    chk(adr == 8'((idx + 1) / 9), "R6", adr, (idx + 1) / 9 % 256);
    if (exp_v) begin
      chk(sum == ws, "R3", sum, ws);
      if (prev_strobe >= 0) chk(idx - prev_strobe == 9, "R7", idx - prev_strobe, 9);
      prev_strobe = idx;
      last_sum = ws;
    end else begin
      chk(sum == last_sum, "R5", sum, last_sum);
    end
    idx++;
  endtask

  task automatic model_reset();
    idx = 0; ws = 8'd0; last_sum = 8'd0; prev_strobe = -1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; smp = '0; cof = '0;
    repeat (2) @(negedge clk);
    chk(sum == 0 && vld == 0 && adr == 0, "R1", {sum, vld, adr}, 0);
    rst = 1'b0;
    model_reset();

    // first window: one product -16*3, then zeros
    step(5'b10000, 3'b011);
    repeat (7) step(5'd0, 3'd0);
    chk(last_sum == 8'd208, "R2", last_sum, 208);
    // nine products of -16*-4 = 64 each, wraps to 64
    repeat (9) step(5'b10000, 3'b100);
    chk(last_sum == 8'd64, "R8", last_sum, 64);
    // 15 * 3 mix with negative extremes
    repeat (9) step(5'b01111, 3'b011);
    repeat (9) step(5'b01111, 3'b100);

    repeat (40) step(5'($urandom), 3'($urandom));

    // asynchronous reset in the middle of a window
    repeat (4) step(5'b10000, 3'b100);
    rst = 1'b1;
    #2;
    chk(sum == 0 && vld == 0 && adr == 0, "R1", {sum, vld, adr}, 0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();

    // long random run, long enough to wrap the address
    for (int i = 0; i < 2400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) step(5'b10000, 3'b100);
      else if (sel == 1) step(5'b01111, 3'b100);
      else step(5'($urandom), 3'($urandom));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule